// File: doc/BRIEF.md
# Indirect Memory-Controller Configuration Block

This block holds the configuration and status registers of a four-bank memory controller and exposes them through just two bus locations. A write to location 0 loads an index register. Location 1 is a data window that reads or writes whichever internal register the index currently selects. Reads have no side effects and return data combinationally. Writes take effect on the next clock edge.

The block also decodes addresses against its bank registers. For every incoming address, it reports which enabled bank contains the address and the offset inside that bank, or it raises a miss flag. An interrupt output follows whether the ECC error-status register is zero or not.

Bank decoding is gated by the global enable bit of the configuration register. Enable and disable transitions of that bit are reflected in the read-only status register.

Top module: `mcfg_window`

## Requirements
- R1: A write with `port_i`=0 stores all 32 bits of `wdata_i` as the index, and a read with `port_i`=0 returns it; after reset the index is 0.
- R2: With `port_i`=1, reads select by index: 0x00 error status A, 0x08 error status B, 0x10 error address, 0x20 configuration, 0x24 status, 0x30 refresh, 0x34 power management, 0x40/0x44/0x48/0x4C banks 0 to 3, 0x94 ECC configuration, 0x98 ECC error status; index 0x80 (timing) and every other index read 0xFFFFFFFF.
- R3: After reset: configuration 0x00800000, refresh 0x05F00000, power management 0x07C00000, and error status, error address, status, ECC configuration, ECC error status and all banks 0.
- R4: Writing either error-status register clears the bits written as one; the error address stores the written value unchanged.
- R5: The status register (0x24) is read-only; a write to it leaves its value unchanged.
- R6: Configuration writes keep bits 31:21 only. When bit 31 goes 0 to 1, status bit 31 clears; when it goes 1 to 0, status bit 31 sets. When bit 30 goes 0 to 1, status bit 30 sets; when it goes 1 to 0, status bit 30 clears.
- R7: Refresh stores value & 0x3FF80000, ECC configuration stores value & 0x00F00000, and power management stores (value & 0xF8000000) | 0x07C00000.
- R8: ECC error status stores value & 0xFFF0F000; `ecc_irq_o` is high from the cycle after a write leaves it non-zero until the cycle after a write leaves it zero.
- R9: Bank registers store value & 0xFFDEE001. In a bank register, bits 31:23 are the base address, bits 19:17 are a size code giving 4 MiB << code, and bit 0 is the valid bit.
- R10: A bank hits `addr_i` when configuration bit 31 is set, the bank's valid bit is set, its size code is not 7, and addr & ~(size-1) equals the base; when configuration bit 31 is clear, every address misses.
- R11: On a hit, `offset_o` = addr & (size-1) of the winning bank; on a miss, `miss_o`=1, `hit_o`=0, and `bank_o` and `offset_o` are 0.
- R12: When several banks hit, the lowest-numbered bank is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the selected port |
| port_i | input | 1 | 0 selects the index, 1 selects the data window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for the selected port |
| ecc_irq_o | output | 1 | ECC error interrupt |
| addr_i | input | 32 | Address to decode against the banks |
| hit_o | output | 1 | Some enabled bank contains the address |
| miss_o | output | 1 | No bank contains the address |
| bank_o | output | 2 | Winning bank number |
| offset_o | output | 32 | Offset of the address within the winning bank |

## Verification
The hardest situation to create is an address that falls inside several valid banks at once while decoding is enabled. It must resolve to the lowest bank, and when that bank is invalidated it must fall through to the next bank.

The stimulus reaches this by programming a 16 MiB bank 0 at address 0 that covers a 4 MiB bank 1 at 8 MiB. It probes an address inside both banks, then clears bank 0's valid bit and probes again. A size-code-7 bank and a global disable round out the miss paths. Throughout, a behavioural model tracks every register and the decode result on each clock.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;
  localparam logic [31:0] IDX_ERRA   = 32'h00;
  localparam logic [31:0] IDX_ERRB   = 32'h08;
  localparam logic [31:0] IDX_EADDR  = 32'h10;
  localparam logic [31:0] IDX_CFG    = 32'h20;
  localparam logic [31:0] IDX_STAT   = 32'h24;
  localparam logic [31:0] IDX_RFR    = 32'h30;
  localparam logic [31:0] IDX_PM     = 32'h34;
  localparam logic [31:0] IDX_BANK0  = 32'h40;
  localparam logic [31:0] IDX_ECFG   = 32'h94;
  localparam logic [31:0] IDX_EERR   = 32'h98;

  localparam logic [31:0] CFG_MASK   = 32'hFFE0_0000;
  localparam logic [31:0] RFR_MASK   = 32'h3FF8_0000;
  localparam logic [31:0] PM_MASK    = 32'hF800_0000;
  localparam logic [31:0] PM_FIXED   = 32'h07C0_0000;
  localparam logic [31:0] ECFG_MASK  = 32'h00F0_0000;
  localparam logic [31:0] EERR_MASK  = 32'hFFF0_F000;
  localparam logic [31:0] BANK_MASK  = 32'hFFDE_E001;

  localparam logic [31:0] CFG_RST    = 32'h0080_0000;
  localparam logic [31:0] RFR_RST    = 32'h05F0_0000;

  localparam int unsigned SIZE_SH0   = 22;  // 4 MiB granule
endpackage

// File: rtl/mcfg_regs.sv
module mcfg_regs
  import mcfg_pkg::*;
#(
  parameter int unsigned NBANK = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic                   port_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  output logic [NBANK-1:0][31:0] bank_o,
  output logic                   dec_en_o,
  output logic                   irq_o,
  output logic [31:0]            idx_o,
  output logic [31:0]            stat_o
);
  logic [31:0] idx_q, erra_q, errb_q, eaddr_q, cfg_q, stat_q, rfr_q, pm_q, ecfg_q, eerr_q;
  logic [NBANK-1:0][31:0] bank_q;
  logic        irq_q;
  logic        win_wr;
  logic [31:0] cfg_new, eerr_new;

  assign win_wr   = wr_i & port_i;
  assign cfg_new  = wdata_i & CFG_MASK;
  assign eerr_new = wdata_i & EERR_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      erra_q  <= '0;
      errb_q  <= '0;
      eaddr_q <= '0;
      cfg_q   <= CFG_RST;
      stat_q  <= '0;
      rfr_q   <= RFR_RST;
      pm_q    <= PM_FIXED;
      ecfg_q  <= '0;
      eerr_q  <= '0;
      irq_q   <= 1'b0;
    end else if (wr_i && !port_i) begin
      idx_q <= wdata_i;
    end else if (win_wr) begin
      case (idx_q)
        IDX_ERRA:  erra_q  <= erra_q & ~wdata_i;
        IDX_ERRB:  errb_q  <= errb_q & ~wdata_i;
        IDX_EADDR: eaddr_q <= wdata_i;
        IDX_CFG: begin
          if (!cfg_q[31] && cfg_new[31])      stat_q[31] <= 1'b0;
          else if (cfg_q[31] && !cfg_new[31]) stat_q[31] <= 1'b1;
          if (!cfg_q[30] && cfg_new[30])      stat_q[30] <= 1'b1;
          else if (cfg_q[30] && !cfg_new[30]) stat_q[30] <= 1'b0;
          cfg_q <= cfg_new;
        end
        IDX_RFR:  rfr_q  <= wdata_i & RFR_MASK;
        IDX_PM:   pm_q   <= (wdata_i & PM_MASK) | PM_FIXED;
        IDX_ECFG: ecfg_q <= wdata_i & ECFG_MASK;
        IDX_EERR: begin
          eerr_q <= eerr_new;
          irq_q  <= |eerr_new;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
    end else if (win_wr) begin
      for (int b = 0; b < NBANK; b++)
        if (idx_q == IDX_BANK0 + 32'(4 * b)) bank_q[b] <= wdata_i & BANK_MASK;
    end
  end

  always_comb begin
    rdata_o = '1;
    if (!port_i) begin
      rdata_o = idx_q;
    end else begin
      case (idx_q)
        IDX_ERRA:  rdata_o = erra_q;
        IDX_ERRB:  rdata_o = errb_q;
        IDX_EADDR: rdata_o = eaddr_q;
        IDX_CFG:   rdata_o = cfg_q;
        IDX_STAT:  rdata_o = stat_q;
        IDX_RFR:   rdata_o = rfr_q;
        IDX_PM:    rdata_o = pm_q;
        IDX_ECFG:  rdata_o = ecfg_q;
        IDX_EERR:  rdata_o = eerr_q;
        default:   rdata_o = '1;
      endcase
      for (int b = 0; b < NBANK; b++)
        if (idx_q == IDX_BANK0 + 32'(4 * b)) rdata_o = bank_q[b];
    end
  end

  assign bank_o   = bank_q;
  assign dec_en_o = cfg_q[31];
  assign irq_o    = irq_q;
  assign idx_o    = idx_q;
  assign stat_o   = stat_q;
endmodule

// File: rtl/mcfg_bank_match.sv
module mcfg_bank_match
  import mcfg_pkg::*;
(
  input  logic        en_i,
  input  logic [31:0] bank_i,
  input  logic [31:0] addr_i,
  output logic        hit_o,
  output logic [31:0] offset_o
);
  logic [2:0]  code;
  logic [4:0]  sh;
  logic [31:0] lo_mask, base;

  assign code    = bank_i[19:17];
  assign sh      = 5'(SIZE_SH0) + {2'b00, code};
  assign lo_mask = ~(32'hFFFF_FFFF << sh);
  assign base    = {bank_i[31:23], 23'b0};
  assign hit_o   = en_i & bank_i[0] & (code != 3'd7) & ((addr_i & ~lo_mask) == base);
  assign offset_o = addr_i & lo_mask;
endmodule

// File: rtl/mcfg_pick.sv
module mcfg_pick #(
  parameter int unsigned NBANK = 4,
  localparam int unsigned BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic [NBANK-1:0]       hits_i,
  input  logic [NBANK-1:0][31:0] offs_i,
  output logic                   hit_o,
  output logic [BW-1:0]          bank_o,
  output logic [31:0]            offset_o
);
  always_comb begin
    hit_o    = 1'b0;
    bank_o   = '0;
    offset_o = '0;
    // scan downward so the lowest hitting bank is assigned last
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (hits_i[b]) begin
        hit_o    = 1'b1;
        bank_o   = BW'(b);
        offset_o = offs_i[b];
      end
    end
  end
endmodule

// File: rtl/mcfg_window.sv
module mcfg_window #(
  parameter int unsigned NBANK = 4,
  localparam int unsigned BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          port_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          ecc_irq_o,
  input  logic [31:0]   addr_i,
  output logic          hit_o,
  output logic          miss_o,
  output logic [BW-1:0] bank_o,
  output logic [31:0]   offset_o
);
  logic [NBANK-1:0][31:0] bank_w;
  logic [NBANK-1:0][31:0] offs_w;
  logic [NBANK-1:0]       hits_w;
  logic                   dec_en_w;
  logic [31:0]            idx_w, stat_w;

  mcfg_regs #(.NBANK(NBANK)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .port_i   (port_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .bank_o   (bank_w),
    .dec_en_o (dec_en_w),
    .irq_o    (ecc_irq_o),
    .idx_o    (idx_w),
    .stat_o   (stat_w)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_match
    mcfg_bank_match u_match (
      .en_i     (dec_en_w),
      .bank_i   (bank_w[g]),
      .addr_i   (addr_i),
      .hit_o    (hits_w[g]),
      .offset_o (offs_w[g])
    );
  end

  mcfg_pick #(.NBANK(NBANK)) u_pick (
    .hits_i   (hits_w),
    .offs_i   (offs_w),
    .hit_o    (hit_o),
    .bank_o   (bank_o),
    .offset_o (offset_o)
  );

  assign miss_o = ~hit_o;
endmodule

// File: rtl/mcfg_chk.sv
module mcfg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_i,
  input logic        port_i,
  input logic [31:0] wdata_i,
  input logic [31:0] idx_w,
  input logic [31:0] stat_w,
  input logic        dec_en_w,
  input logic        ecc_irq_o,
  input logic        miss_o,
  input logic [31:0] offset_o
);
  assert_status_ro_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && port_i && idx_w == 32'h24) |=> $stable(stat_w));

  assert_irq_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && port_i && idx_w == 32'h98 && (wdata_i & 32'hFFF0F000) != 0) |=> ecc_irq_o);

  assert_irq_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && port_i && idx_w == 32'h98 && (wdata_i & 32'hFFF0F000) == 0) |=> !ecc_irq_o);

  assert_disabled_miss_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_en_w |-> miss_o);

  assert_enable_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dec_en_w) |-> !stat_w[31]);

  assert_disable_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dec_en_w) |-> stat_w[31]);

  assert_miss_zero_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> offset_o == 32'h0);
endmodule

bind mcfg_window mcfg_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .port_i    (port_i),
  .wdata_i   (wdata_i),
  .idx_w     (idx_w),
  .stat_w    (stat_w),
  .dec_en_w  (dec_en_w),
  .ecc_irq_o (ecc_irq_o),
  .miss_o    (miss_o),
  .offset_o  (offset_o)
);

// File: tb/mcfg_window_tb.sv
module mcfg_window_tb_top;
  localparam int CLK = 10;

  logic        clk_i = 0, rst_ni = 0, wr_i = 0, port_i = 0;
  logic [31:0] wdata_i = 0, addr_i = 0;
  logic [31:0] rdata_o, offset_o;
  logic        ecc_irq_o, hit_o, miss_o;
  logic [1:0]  bank_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  mcfg_window dut_i (.*);

  always #(CLK/2) clk_i = ~clk_i;

  // behavioural reference
  logic [31:0] m_idx, m_erra, m_errb, m_eaddr, m_cfg, m_stat, m_rfr, m_pm, m_ecfg, m_eerr;
  logic [31:0] m_bank [4];
  bit          m_irq;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_idx = 0; m_erra = 0; m_errb = 0; m_eaddr = 0; m_cfg = 32'h00800000;
      m_stat = 0; m_rfr = 32'h05F00000; m_pm = 32'h07C00000; m_ecfg = 0; m_eerr = 0;
      m_irq = 0;
      foreach (m_bank[i]) m_bank[i] = 0;
    end else if (wr_i) begin
      if (!port_i) m_idx = wdata_i;
      else begin
        logic [31:0] v;
        v = wdata_i;
        if (m_idx == 32'h00) m_erra &= ~v;
        if (m_idx == 32'h08) m_errb &= ~v;
        if (m_idx == 32'h10) m_eaddr = v;
        if (m_idx == 32'h20) begin
          logic [31:0] nv;
          nv = v & 32'hFFE00000;
          if (nv[31] != m_cfg[31]) m_stat[31] = !nv[31];
          if (nv[30] != m_cfg[30]) m_stat[30] = nv[30];
          m_cfg = nv;
        end
        if (m_idx == 32'h30) m_rfr = v & 32'h3FF80000;
        if (m_idx == 32'h34) m_pm = (v & 32'hF8000000) | 32'h07C00000;
        if (m_idx == 32'h94) m_ecfg = v & 32'h00F00000;
        if (m_idx == 32'h98) begin
          m_eerr = v & 32'hFFF0F000;
          m_irq = (m_eerr != 0);
        end
        for (int i = 0; i < 4; i++)
          if (m_idx == 32'h40 + 4*i) m_bank[i] = v & 32'hFFDEE001;
      end
    end
  end

  function automatic logic [31:0] m_read(bit p);
    if (!p) return m_idx;
    case (m_idx)
      32'h00: return m_erra;
      32'h08: return m_errb;
      32'h10: return m_eaddr;
      32'h20: return m_cfg;
      32'h24: return m_stat;
      32'h30: return m_rfr;
      32'h34: return m_pm;
      32'h40: return m_bank[0];
      32'h44: return m_bank[1];
      32'h48: return m_bank[2];
      32'h4C: return m_bank[3];
      32'h94: return m_ecfg;
      32'h98: return m_eerr;
      default: return 32'hFFFFFFFF;
    endcase
  endfunction

  // returns {hit, bank[1:0], offset}
  function automatic logic [34:0] m_look(logic [31:0] a);
    if (!m_cfg[31]) return '0;
    for (int i = 0; i < 4; i++) begin
      longint size, base;
      int code;
      code = m_bank[i][19:17];
      if (!m_bank[i][0] || code == 7) continue;
      size = 64'h400000 << code;
      base = m_bank[i] & 32'hFF800000;
      if ((longint'(a) / size) * size == base)
        return {1'b1, 2'(i), 32'(longint'(a) % size)};
    end
    return '0;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk_i) begin
    #(CLK/4);
    if (rst_ni && !done) begin
      logic [34:0] e;
      e = m_look(addr_i);
      chk(rdata_o == m_read(port_i), "R2 cycle rdata", rdata_o, m_read(port_i));
      chk(ecc_irq_o == m_irq, "R8 cycle irq", 32'(ecc_irq_o), 32'(m_irq));
      chk(hit_o == e[34] && miss_o == !e[34] && bank_o == e[33:32] && offset_o == e[31:0],
          "R10 cycle decode", {hit_o, bank_o, offset_o[28:0]}, {e[34:32], e[28:0]});
    end
  end

  task automatic wr(bit p, logic [31:0] d);
    @(negedge clk_i);
    wr_i = 1; port_i = p; wdata_i = d;
    @(negedge clk_i);
    wr_i = 0;
  endtask

  task automatic wd(logic [31:0] idx, logic [31:0] v);
    wr(0, idx);
    wr(1, v);
  endtask

  task automatic rd(logic [31:0] idx, logic [31:0] exp, string tag);
    wr(0, idx);
    port_i = 1;
    #(CLK/4);
    chk(rdata_o === exp, tag, rdata_o, exp);
  endtask

  task automatic look(logic [31:0] a, bit h, logic [1:0] b, logic [31:0] off, string tag);
    @(negedge clk_i);
    addr_i = a;
    #(CLK/4);
    chk(hit_o === h && miss_o === !h && bank_o === b && offset_o === off, tag,
        {hit_o, miss_o, bank_o, offset_o[27:0]}, {h, !h, b, off[27:0]});
  endtask

  task automatic irq_is(bit e, string tag);
    #(CLK/4);
    chk(ecc_irq_o === e, tag, 32'(ecc_irq_o), 32'(e));
  endtask

  initial begin
    #(CLK * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R3 reset state, R1 index reset
    #(CLK/4);
    chk(rdata_o === 32'h0, "R1 reset index", rdata_o, 0);
    chk(ecc_irq_o === 1'b0, "R3 reset irq", 32'(ecc_irq_o), 0);
    rd(32'h20, 32'h00800000, "R3 cfg reset");
    rd(32'h30, 32'h05F00000, "R3 refresh reset");
    rd(32'h34, 32'h07C00000, "R3 pm reset");
    rd(32'h24, 32'h0, "R3 status reset");
    rd(32'h98, 32'h0, "R3 ecc err reset");
    rd(32'h4C, 32'h0, "R3 bank3 reset");
    // R1 index readback
    wr(0, 32'hDEAD0044);
    port_i = 0; #(CLK/4);
    chk(rdata_o === 32'hDEAD0044, "R1 index readback", rdata_o, 32'hDEAD0044);
    // R2 unknown and timing indices
    rd(32'hDEAD0044, 32'hFFFFFFFF, "R2 unknown wide index");
    rd(32'h04, 32'hFFFFFFFF, "R2 unknown index");
    wd(32'h80, 32'h0);
    rd(32'h80, 32'hFFFFFFFF, "R2 timing reads ones");
    // R4
    wd(32'h00, 32'hFFFFFFFF);
    rd(32'h00, 32'h0, "R4 err A w1c");
    wd(32'h08, 32'hFFFFFFFF);
    rd(32'h08, 32'h0, "R4 err B w1c");
    wd(32'h10, 32'h12345678);
    rd(32'h10, 32'h12345678, "R4 error address");
    // R7
    wd(32'h30, 32'hFFFFFFFF);
    rd(32'h30, 32'h3FF80000, "R7 refresh mask");
    wd(32'h34, 32'h0);
    rd(32'h34, 32'h07C00000, "R7 pm fixed bits");
    wd(32'h34, 32'hFFFFFFFF);
    rd(32'h34, 32'hFFC00000, "R7 pm full");
    wd(32'h94, 32'hFFFFFFFF);
    rd(32'h94, 32'h00F00000, "R7 ecc cfg mask");
    // R6
    wd(32'h20, 32'hC01FFFFF);
    rd(32'h20, 32'hC0000000, "R6 cfg mask");
    rd(32'h24, 32'h40000000, "R6 enable edges");
    // R5
    wd(32'h24, 32'h0);
    rd(32'h24, 32'h40000000, "R5 status read-only");
    wd(32'h20, 32'h0);
    rd(32'h24, 32'h80000000, "R6 disable edges");
    wd(32'h20, 32'h80000000);
    rd(32'h24, 32'h00000000, "R6 re-enable");
    // R9
    wd(32'h48, 32'hFFFFFFFF);
    rd(32'h48, 32'hFFDEE001, "R9 bank mask");
    wd(32'h40, 32'h00040001);
    wd(32'h44, 32'h00800001);
    wd(32'h48, 32'h100E0001);
    wd(32'h4C, 32'h200C0001);
    rd(32'h44, 32'h00800001, "R9 bank1 store");
    // R10 R11 R12
    look(32'h00900000, 1, 2'd0, 32'h00900000, "R12 overlap lowest");
    look(32'h01234567, 0, 2'd0, 32'h0, "R11 miss zero");
    look(32'h2ABCDEF0, 1, 2'd3, 32'h0ABCDEF0, "R11 offset bank3");
    look(32'h10000010, 0, 2'd0, 32'h0, "R10 code7 never hits");
    wd(32'h40, 32'h00040000);
    look(32'h00900000, 1, 2'd1, 32'h00100000, "R12 fall through");
    wd(32'h20, 32'h0);
    look(32'h2ABCDEF0, 0, 2'd0, 32'h0, "R10 disabled miss");
    // R8
    wd(32'h98, 32'h000F0FFF);
    irq_is(0, "R8 masked zero no irq");
    rd(32'h98, 32'h0, "R8 masked read");
    wd(32'h98, 32'h00001000);
    irq_is(1, "R8 irq rises");
    rd(32'h98, 32'h00001000, "R8 stored value");
    wd(32'h98, 32'h80000000);
    irq_is(1, "R8 irq stays");
    wd(32'h98, 32'h0);
    irq_is(0, "R8 irq falls");
    repeat (4) @(negedge clk_i);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule